// File: doc/BRIEF.md
# Non-Redundant Signed-Digit Coefficient Encoder

The encoder turns a two's-complement coefficient of N bits (N even) into N/2 radix-4 signed digits that can be written into a coefficient memory ahead of time. The multiplier that later reads them then needs no encoding logic of its own. Each digit below the top one is limited to four values and so takes only 2 bits of storage. The top digit keeps the wider five-value set so that the whole two's-complement range can be reached, and it is stored as sign, magnitude-one and magnitude-two flags.

The digits come out of a serial carry chain. Each digit uses two half-adder-like cells. The first cell adds the even input bit to the incoming carry. The second cell folds in the odd bit and passes a positively weighted carry to the next digit. A parameter chooses between the set {-2,-1,0,+1} and its mirror {-1,0,+1,+2}. The result is held in one register stage that has a valid/ready handshake on both sides.

Top module: `nrsd_coef_encoder`

## Requirements
- R1: While rst_ni is low and directly after reset, out_valid_o is 0 and in_ready_o is 1.
- R2: A word accepted on a rising edge where in_valid_i and in_ready_o are both 1 shows its encoding on the outputs with out_valid_o = 1 after that same edge.
- R3: While out_valid_o is 1 and out_ready_i is 0, in_ready_o is 0, and lo_digits_o and msd_o keep their values.
- R4: When out_valid_o and out_ready_i are 1 and in_valid_i is 0, out_valid_o is 0 after the next edge. When in_valid_i is also 1, the new word is taken in the same cycle.
- R5: The sum of digit_j·4^j over all digits, with the top digit as index N/2−1, equals the signed value of the accepted coefficient.
- R6: Low digit j sits in lo_digits_o[2j+1:2j]; bit 2j+1 is h and bit 2j is l. With POS_SET=0 its value is l−2h, which lies in {-2,-1,0,+1}.
- R7: With POS_SET=1 the value of a low digit is 2h−l, which lies in {-1,0,+1,+2}.
- R8: msd_o is {s,two,one} in bits 2,1,0. Zero is 000. one and two are never both set, and s is set only for a nonzero value.
- R9: The chain starts with carry 0, so with POS_SET=0 digit 0 equals b0−2·b1. Coefficients 1, 2 and 3 encode to low fields 0x0001, 0x0006 and 0x0007.
- R10: With POS_SET=0 and N=16, -32768 gives msd_o=110 with all low digits zero, and 32767 gives msd_o=010 with lo_digits_o=0x0003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Coefficient is present |
| in_ready_o | output | 1 | Encoder can take a coefficient |
| coef_i | input | COEF_W | Two's-complement coefficient |
| out_valid_o | output | 1 | Encoded digits are present |
| out_ready_i | input | 1 | Consumer takes the digits |
| lo_digits_o | output | COEF_W-2 | Packed 2-bit low digits |
| msd_o | output | 3 | Top digit as {s,two,one} |

## Verification
On every cycle the assertions check four things: that the value rebuilt from the registered digits equals the accepted coefficient, that the top-digit flags are well formed, that stalls hold the output, and that an output with no new input drains. The exact bit patterns at the range extremes, the start of the chain for small values, and the mirrored digit set can only be shown by the bench's scenarios. The bench covers every 8-bit input for both variants, random 16-bit inputs, and a table of hand-worked codes.

// File: rtl/nrsd_pkg.sv
package nrsd_pkg;
  typedef struct packed {
    logic s;
    logic two;
    logic one;
  } msd_code_t;

  function automatic logic signed [2:0] msd_value(input msd_code_t c);
    logic signed [2:0] m;
    m = c.two ? 3'sd2 : (c.one ? 3'sd1 : 3'sd0);
    return c.s ? -m : m;
  endfunction

  function automatic logic signed [2:0] lo_value(input logic [1:0] code, input bit pos_set);
    logic signed [2:0] h2, l;
    h2 = code[1] ? 3'sd2 : 3'sd0;
    l  = code[0] ? 3'sd1 : 3'sd0;
    return pos_set ? (h2 - l) : (l - h2);
  endfunction
endpackage

// File: rtl/nrsd_digit_cell.sv
module nrsd_digit_cell #(
  parameter bit POS_SET = 1'b0
) (
  input  logic [1:0] b_i,
  input  logic       c_i,
  output logic       c_o,
  output logic [1:0] code_o
);
  logic c_mid, n_lo, n_hi;

  generate
    if (POS_SET) begin : g_pos
      // negative-weight sum at even position, positive at odd
      always_comb begin
        c_mid = b_i[0] | c_i;
        n_lo  = b_i[0] ^ c_i;
        c_o   = b_i[1] & c_mid;
        n_hi  = b_i[1] ^ c_mid;
      end
    end else begin : g_neg
      always_comb begin
        c_mid = b_i[0] & c_i;
        n_lo  = b_i[0] ^ c_i;
        c_o   = b_i[1] | c_mid;
        n_hi  = b_i[1] ^ c_mid;
      end
    end
  endgenerate

  assign code_o = {n_hi, n_lo};
endmodule

// File: rtl/nrsd_msd_cell.sv
module nrsd_msd_cell
  import nrsd_pkg::*;
(
  input  logic [1:0] b_i,
  input  logic       c_i,
  output msd_code_t  code_o
);
  // value = -2*b[1] + b[0] + c
  logic both;
  assign both       = b_i[0] & c_i;
  assign code_o.one = b_i[0] ^ c_i;
  assign code_o.s   = b_i[1] & ~both;
  assign code_o.two = b_i[1] ? ~(b_i[0] | c_i) : both;
endmodule

// File: rtl/nrsd_coef_encoder.sv
module nrsd_coef_encoder
  import nrsd_pkg::*;
#(
  parameter int unsigned COEF_W  = 16,
  parameter bit          POS_SET = 1'b0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [COEF_W-1:0]     coef_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [COEF_W-3:0]     lo_digits_o,
  output logic [2:0]            msd_o
);
  localparam int unsigned NDIG = COEF_W / 2;
  localparam int unsigned LO_W = 2 * (NDIG - 1);
  localparam int unsigned RW   = COEF_W + 3;

  logic [NDIG-1:0] carry;
  logic [LO_W-1:0] lo_d, lo_q;
  msd_code_t       msd_d, msd_q;
  logic            valid_q, accept;

  assign carry[0] = 1'b0;

  for (genvar j = 0; j < NDIG - 1; j++) begin : g_dig
    nrsd_digit_cell #(.POS_SET(POS_SET)) u_cell (
      .b_i    (coef_i[2*j+1:2*j]),
      .c_i    (carry[j]),
      .c_o    (carry[j+1]),
      .code_o (lo_d[2*j+1:2*j])
    );
  end

  nrsd_msd_cell u_msd (
    .b_i    (coef_i[COEF_W-1:COEF_W-2]),
    .c_i    (carry[NDIG-1]),
    .code_o (msd_d)
  );

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      lo_q    <= '0;
      msd_q   <= '0;
    end else begin
      if (in_ready_o) valid_q <= in_valid_i;
      if (accept) begin
        lo_q  <= lo_d;
        msd_q <= msd_d;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign lo_digits_o = lo_q;
  assign msd_o       = msd_q;

  // weighted rebuild of the registered digits
  logic signed [RW-1:0] recon;
  always_comb begin
    recon = RW'(msd_value(msd_q)) <<< (2 * (NDIG - 1));
    for (int j = 0; j < NDIG - 1; j++)
      recon = recon + (RW'(lo_value(lo_q[2*j+1 -: 2], POS_SET)) <<< (2 * j));
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o) else $error("accept lost"); // R2
  AST_VALUE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (recon == RW'($signed($past(coef_i))))) else $error("value mismatch"); // R5
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(lo_digits_o) && $stable(msd_o)))
    else $error("stall broke"); // R3
  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !in_valid_i) |=> !out_valid_o) else $error("no drain"); // R4
  AST_MSD_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (!(msd_q.one && msd_q.two) && (!msd_q.s || msd_q.one || msd_q.two)))
    else $error("bad top code"); // R8
endmodule

// File: tb/sim_nrsd_coef_encoder.sv
`timescale 1ns/1ps
module sim_nrsd_coef_encoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] coef = '0;
  logic        rdy0, rdy1, rdy2, ov0, ov1, ov2;
  logic [13:0] lo0;
  logic [5:0]  lo1, lo2;
  logic [2:0]  m0, m1, m2;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nrsd_coef_encoder #(.COEF_W(16), .POS_SET(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy0), .coef_i(coef),
    .out_valid_o(ov0), .out_ready_i(out_ready), .lo_digits_o(lo0), .msd_o(m0));
  nrsd_coef_encoder #(.COEF_W(8), .POS_SET(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy1), .coef_i(coef[7:0]),
    .out_valid_o(ov1), .out_ready_i(out_ready), .lo_digits_o(lo1), .msd_o(m1));
  nrsd_coef_encoder #(.COEF_W(8), .POS_SET(1'b0)) u2 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(rdy2), .coef_i(coef[7:0]),
    .out_valid_o(ov2), .out_ready_i(out_ready), .lo_digits_o(lo2), .msd_o(m2));

  // {coef, lo digits, top code}
  localparam logic [32:0] TBL [10] = '{
    {16'h0000, 14'h0000, 3'b000}, {16'h0001, 14'h0001, 3'b000},
    {16'h0002, 14'h0006, 3'b000}, {16'h0003, 14'h0007, 3'b000},
    {16'h7FFF, 14'h0003, 3'b010}, {16'h8000, 14'h0000, 3'b110},
    {16'hFFFF, 14'h0003, 3'b000}, {16'h4000, 14'h0000, 3'b001},
    {16'hC000, 14'h0000, 3'b101}, {16'hFFFE, 14'h0002, 3'b000}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int top_val(input logic [2:0] t);
    int m;
    m = t[1] ? 2 : (t[0] ? 1 : 0);
    return t[2] ? -m : m;
  endfunction

  function automatic bit top_ok(input logic [2:0] t);
    return !(t[1] && t[0]) && (!t[2] || t[1] || t[0]);
  endfunction

  function automatic int decode(input logic [13:0] lo, input logic [2:0] t, input int ndig, input bit pos);
    int s, w;
    s = 0; w = 1;
    for (int j = 0; j < ndig - 1; j++) begin
      s += (pos ? (2 * int'(lo[2*j+1]) - int'(lo[2*j])) : (int'(lo[2*j]) - 2 * int'(lo[2*j+1]))) * w;
      w *= 4;
    end
    return s + top_val(t) * w;
  endfunction

  task automatic check_all(input logic [15:0] c);
    int e16, e8;
    e16 = int'($signed(c));
    e8  = int'($signed(c[7:0]));
    check(ov0 && ov1 && ov2, "R2", int'(ov0), 1);
    check(decode(lo0, m0, 8, 1'b0) == e16, "R5 R6", decode(lo0, m0, 8, 1'b0), e16);
    check(decode({8'h0, lo1}, m1, 4, 1'b1) == e8, "R5 R7", decode({8'h0, lo1}, m1, 4, 1'b1), e8);
    check(decode({8'h0, lo2}, m2, 4, 1'b0) == e8, "R5 R6", decode({8'h0, lo2}, m2, 4, 1'b0), e8);
    check(top_ok(m0) && top_ok(m1) && top_ok(m2), "R8", int'(m1), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!ov0 && !ov1 && !ov2, "R1", int'(ov0), 0);
    check(rdy0 && rdy1 && rdy2, "R1", int'(rdy0), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!ov0 && rdy0, "R1", int'(ov0), 0);

    // table: exact codes, chain start R9, extremes R10
    foreach (TBL[i]) begin
      coef = TBL[i][32:17]; in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      check(ov0, "R2", int'(ov0), 1);
      check(lo0 == TBL[i][16:3], "R9 R10", int'(lo0), int'(TBL[i][16:3]));
      check(m0 == TBL[i][2:0], "R10 R8", int'(m0), int'(TBL[i][2:0]));
      check_all(coef);
    end

    for (int i = 0; i < 256; i++) begin
      coef = {16'($urandom_range(255, 0))} << 8 | 16'(i);
      @(negedge clk);
      check_all(coef);
    end
    for (int i = 0; i < 400; i++) begin
      coef = 16'($urandom);
      @(negedge clk);
      check_all(coef);
    end

    in_valid = 1'b0;
    @(negedge clk);
    check(!ov0 && !ov1, "R4", int'(ov0), 0);

    coef = 16'h1234; in_valid = 1'b1;
    @(negedge clk);
    check_all(16'h1234);
    out_ready = 1'b0; coef = 16'h0F0F;
    @(negedge clk);
    check(!rdy0 && !rdy1, "R3", int'(rdy0), 0);
    check(decode(lo0, m0, 8, 1'b0) == 32'h1234, "R3", decode(lo0, m0, 8, 1'b0), 32'h1234);
    @(negedge clk);
    check(ov0 && decode(lo0, m0, 8, 1'b0) == 32'h1234, "R3", decode(lo0, m0, 8, 1'b0), 32'h1234);
    out_ready = 1'b1;
    @(negedge clk);
    check(decode(lo0, m0, 8, 1'b0) == 32'h0F0F, "R4", decode(lo0, m0, 8, 1'b0), 32'h0F0F);
    check_all(16'h0F0F);
    in_valid = 1'b0;
    @(negedge clk);
    check(!ov0 && !ov2, "R4", int'(ov0), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule